// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a data word by a fixed number of clock cycles, set at compile time. Long delays use a single-clock RAM with a circular pointer instead of a long chain of flip-flops. The stored words are never reset, so the RAM can map onto dense memory. Delays at or below a small threshold use a plain register chain, which costs less than a RAM at that size.

In the default sizing mode the RAM depth is the next power of two at or above the delay. The pointer then wraps on its own binary overflow, and the read address is the write address minus a fixed offset. In the tight sizing mode the depth is exactly the number of words the delay needs. The pointer wraps by an explicit compare, and each cycle the RAM reads a slot before overwriting that same slot. In both modes the one-cycle RAM read latency is already counted, so the delay from input to output equals the parameter exactly.

A valid flag tells the consumer when the output first carries a word that was sampled after reset.

Top module: `ram_delay_line`

## Requirements
- R1: In power-of-two mode with DELAY above CHAIN_MAX, `dout` sampled after the k-th rising edge since reset equals the `din` sampled at edge k-DELAY+1, for all k >= DELAY.
- R2: In tight mode with DELAY above CHAIN_MAX, the same exact-latency relation holds. The pointer counts 0 to DEPTH-1 and returns to 0, where DEPTH = DELAY-1.
- R3: With DELAY at most CHAIN_MAX, the block is a register chain with the same exact DELAY-cycle latency.
- R4: `dout_valid` is 0 during reset and after edges 1 to DELAY-1 following reset release. It becomes 1 at edge DELAY.
- R5: Once high, `dout_valid` stays high until reset. Asserting reset again clears it, and the fill count starts over from zero.
- R6: The exact-latency relation holds when DELAY is itself a power of two, in which case the RAM depth equals DELAY.
- R7: The default configuration (16-bit word, 2044 cycles, power-of-two mode, depth 2048) meets the exact-latency relation.
- R8: The relation keeps holding over many pointer wraps, and for data patterns that are counting, random, or alternating all-zeros and all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the control state only |
| din | input | WIDTH | Word sampled every cycle |
| dout | output | WIDTH | Word sampled DELAY cycles earlier |
| dout_valid | output | 1 | High once the line has filled since reset |

## Verification
A counting pattern comes first. It makes any off-by-one latency or wrong pointer offset show up as a constant difference between the output and the expected value. Random words from a seeded generator then catch address aliasing, and also a stale slot being returned in place of a fresh one, which a smooth ramp could hide. Alternating all-zeros and all-ones words, sent after a reset in the middle of the run, check that the fill count restarts and that every data bit toggles. Five copies run side by side: a register chain, power-of-two mode, tight mode, an exact power-of-two delay, and the default 2044-cycle configuration.

// File: rtl/dly_pkg.sv
package dly_pkg;
   function automatic int unsigned pow2_ceil(input int unsigned n);
      int unsigned p;
      p = 1;
      while (p < n) p = p * 2;
      return p;
   endfunction

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth < 2) ? 1 : $clog2(depth);
   endfunction
endpackage

// File: rtl/dly_chain.sv
module dly_chain #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 4
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage [STAGES];

   always_ff @(posedge clk) stage[0] <= d;

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) stage[i] <= stage[i-1];
   end

   assign q = stage[STAGES-1];
endmodule

// File: rtl/dly_ptr.sv
module dly_ptr #(
   parameter int unsigned DEPTH = 16,
   parameter bit          TIGHT = 1'b0,
   localparam int unsigned AW   = dly_pkg::addr_bits(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [AW-1:0] ptr
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   if (TIGHT) begin : g_tight
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)            ptr <= '0;
         else if (ptr == LAST)  ptr <= '0;
         else                   ptr <= ptr + 1'b1;
      end
   end else begin : g_pow2
      initial begin
         if ((1 << AW) != DEPTH) $error("dly_ptr: DEPTH must be a power of two in modular mode");
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ptr <= '0;
         else        ptr <= ptr + 1'b1;
      end
   end

   a_r2_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
   a_r2_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr == LAST) |=> (ptr == '0));
   a_r1_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr != LAST) |=> (ptr == $past(ptr) + 1'b1));
endmodule

// File: rtl/dly_ram.sv
module dly_ram #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 16,
   localparam int unsigned AW   = dly_pkg::addr_bits(DEPTH)
) (
   input  logic             clk,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   logic [WIDTH-1:0] mem [DEPTH];

   // read sees the old contents when raddr == waddr
   always_ff @(posedge clk) begin
      rdata       <= mem[raddr];
      mem[waddr]  <= wdata;
   end
endmodule

// File: rtl/dly_fill.sv
module dly_fill #(
   parameter int unsigned COUNT = 16,
   localparam int unsigned CW   = $clog2(COUNT + 1)
) (
   input  logic clk,
   input  logic rst_n,
   output logic full
);
   localparam logic [CW-1:0] TOP = CW'(COUNT);
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (cnt != TOP) cnt <= cnt + 1'b1;
   end

   assign full = (cnt == TOP);

   a_r4_cnt_bounded: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= TOP);
   a_r5_full_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      full |=> full);
   a_r4_full_on_step: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> (cnt == TOP) && ($past(cnt) == TOP - 1'b1));
endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line #(
   parameter int unsigned WIDTH     = 16,
   parameter int unsigned DELAY     = 2044,
   parameter bit          TIGHT     = 1'b0,
   parameter int unsigned CHAIN_MAX = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout,
   output logic             dout_valid
);
   initial begin
      if (WIDTH < 1)     $error("ram_delay_line: WIDTH must be at least 1");
      if (DELAY < 1)     $error("ram_delay_line: DELAY must be at least 1");
      if (CHAIN_MAX < 2) $error("ram_delay_line: CHAIN_MAX must be at least 2");
   end

   dly_fill #(.COUNT(DELAY)) u_fill (
      .clk   (clk),
      .rst_n (rst_n),
      .full  (dout_valid)
   );

   if (DELAY <= CHAIN_MAX) begin : g_chain
      dly_chain #(.WIDTH(WIDTH), .STAGES(DELAY)) u_chain (
         .clk (clk),
         .d   (din),
         .q   (dout)
      );
   end else begin : g_ram
      // one cycle of RAM read latency is part of the delay
      localparam int unsigned SPAN  = DELAY - 1;
      localparam int unsigned DEPTH = TIGHT ? SPAN : dly_pkg::pow2_ceil(DELAY);
      localparam int unsigned AW    = dly_pkg::addr_bits(DEPTH);
      localparam logic [AW-1:0] OFS = AW'(SPAN % DEPTH);

      logic [AW-1:0] wptr;
      logic [AW-1:0] rptr;

      dly_ptr #(.DEPTH(DEPTH), .TIGHT(TIGHT)) u_ptr (
         .clk   (clk),
         .rst_n (rst_n),
         .ptr   (wptr)
      );

      if (TIGHT) begin : g_same_slot
         assign rptr = wptr;
      end else begin : g_offset
         assign rptr = wptr - OFS;
      end

      dly_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_ram (
         .clk   (clk),
         .waddr (wptr),
         .wdata (din),
         .raddr (rptr),
         .rdata (dout)
      );
   end

   a_r5_valid_low_in_reset: assert property (@(posedge clk)
      !rst_n |-> !dout_valid);
endmodule

// File: tb/ram_delay_line_test.sv
module ram_delay_line_test;
   localparam int CLK_PERIOD = 10;
   localparam int W    = 16;
   localparam int HMSK = 8191;

   localparam int D_CH = 13;
   localparam int D_P2 = 37;
   localparam int D_TI = 37;
   localparam int D_EX = 32;
   localparam int D_DF = 2044;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] din = '0;
   logic [W-1:0] q_ch, q_p2, q_ti, q_ex, uut_q;
   logic         v_ch, v_p2, v_ti, v_ex, uut_v;

   logic [W-1:0] hist [HMSK+1];
   int k;
   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ram_delay_line #(.WIDTH(W), .DELAY(D_CH)) i_ch (.clk(clk), .rst_n(rst_n), .din(din), .dout(q_ch), .dout_valid(v_ch));
   ram_delay_line #(.WIDTH(W), .DELAY(D_P2)) i_p2 (.clk(clk), .rst_n(rst_n), .din(din), .dout(q_p2), .dout_valid(v_p2));
   ram_delay_line #(.WIDTH(W), .DELAY(D_TI), .TIGHT(1'b1)) i_ti (.clk(clk), .rst_n(rst_n), .din(din), .dout(q_ti), .dout_valid(v_ti));
   ram_delay_line #(.WIDTH(W), .DELAY(D_EX)) i_ex (.clk(clk), .rst_n(rst_n), .din(din), .dout(q_ex), .dout_valid(v_ex));
   ram_delay_line uut (.clk(clk), .rst_n(rst_n), .din(din), .dout(uut_q), .dout_valid(uut_v));

   function automatic logic [W-1:0] expect_word(input int edge_no, input int d);
      return hist[(edge_no - d + 1) & HMSK];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at edge %0d", req, act, exp, k);
      end
   endtask

   task automatic check_line(input string req, input int d, input logic [W-1:0] q, input logic v);
      check(v == (k >= d), {req, " valid (R4)"}, int'(v), int'(k >= d));
      if (k >= d) check(q == expect_word(k, d), req, int'(q), int'(expect_word(k, d)));
   endtask

   task automatic check_all();
      check_line("R3 chain", D_CH, q_ch, v_ch);
      check_line("R1 pow2", D_P2, q_p2, v_p2);
      check_line("R2 tight", D_TI, q_ti, v_ti);
      check_line("R6 exact-pow2", D_EX, q_ex, v_ex);
      check_line("R7 default", D_DF, uut_q, uut_v);
   endtask

   // one cycle: present next word, clock it, check at the falling edge
   task automatic step(input logic [W-1:0] w);
      din = w;
      hist[(k + 1) & HMSK] = w;
      @(posedge clk);
      @(negedge clk);
      k++;
      check_all();
   endtask

   task automatic restart();
      rst_n = 1'b0;
      #1;
      check(!v_ch && !v_p2 && !v_ti && !v_ex && !uut_v, "R5 valid cleared by reset", int'(uut_v), 0);
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      k = 0;
   endtask

   initial begin
      void'($urandom(32'd7321));
      @(negedge clk);
      @(negedge clk);
      check(!v_ch && !v_p2 && !v_ti && !v_ex && !uut_v, "R4 valid low in reset", int'(uut_v), 0);
      rst_n = 1'b1;
      k = 0;
      // R8 counting pattern, many wraps for the small lines
      for (int i = 0; i < 2600; i++) step(W'(i * 3 + 1));
      // R8 random words
      for (int i = 0; i < 2600; i++) step(W'($urandom));
      // R5 mid-run reset, then R8 alternating extremes
      restart();
      for (int i = 0; i < 2300; i++) step((i % 2 == 0) ? '0 : '1);
      // R5 valid stays up after the fill
      check(uut_v && v_ti, "R5 valid stays high", int'(uut_v), 1);
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule